// File: doc/BRIEF.md
# Floating-Point Arithmetic Trap Decision Unit

This block sits after a floating-point execution pipe. Each cycle it may receive the five IEEE exception flags produced by one completed operation, together with the operation's 11-bit qualifier field, a flag marking float-to-integer conversions, and the destination register number. It filters the flags according to the qualifiers and decides whether an arithmetic trap must be taken. The trap is reported one cycle later as a single-cycle pulse with a 5-bit summary code.

Two trap paths exist. Without software completion, every flag that survives qualifier filtering traps and the enable mask plays no part. With software completion, the surviving flags are first accumulated into a sticky status register, and only those not disabled in a software-loaded disable mask cause a trap. On every trap, one bit of a 64-bit register-trap mask is set to record which floating-point destination registers caused traps. Sticky status and the register-trap mask clear only on the synchronous clear input or on reset.

Top module: `fp_trap_unit`

## Requirements
- R1: After reset, trap_o, trap_code_o, sticky_o, mask_o and reg_mask_o are all zero.
- R2: Flags and trap code share one bit layout: bit 0 invalid, bit 1 divide-by-zero, bit 2 overflow, bit 3 underflow, bit 4 inexact; the code equals exactly the flags that caused the trap, and is zero when no trap is reported.
- R3: The inexact flag is removed before any decision or accumulation unless qualifier bit 9 is set.
- R4: When cvt_i is high, the overflow flag is removed unless qualifier bit 8 is set; when cvt_i is low, bit 8 has no effect on overflow.
- R5: With qualifier bit 10 clear, a trap fires whenever any filtered flag remains, whatever the disable mask holds, and sticky_o is unchanged.
- R6: With qualifier bit 10 set, the filtered flags are ORed into sticky_o, which never loses bits except through clear.
- R7: With qualifier bit 10 set, a trap fires only if the filtered flags ANDed with the inverse of the disable mask are nonzero, and the code holds those bits.
- R8: trap_o is registered: it rises in the cycle after an accepted operation (op_valid_i high) and never without one.
- R9: On every trap, bit dst_i+32 of reg_mask_o becomes set; bits 31..0 are never set.
- R10: clr_i zeroes sticky_o and reg_mask_o at the next edge and overrides any accumulation from an operation in the same cycle; that operation's trap pulse is still reported.
- R11: mask_we_i loads mask_i into the disable mask (1 = flag disabled) at the next edge; an operation in the same cycle still uses the previous mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | A completed operation presents its flags this cycle |
| flags_i | input | 5 | Raised exception flags (layout in R2) |
| qual_i | input | 11 | Qualifier field; bits 10, 9, 8 used |
| cvt_i | input | 1 | Operation is a float-to-integer conversion |
| dst_i | input | 5 | Destination floating-point register number |
| mask_we_i | input | 1 | Load the disable mask |
| mask_i | input | 5 | New disable mask value |
| clr_i | input | 1 | Synchronous clear of sticky status and register-trap mask |
| trap_o | output | 1 | Single-cycle trap pulse |
| trap_code_o | output | 5 | Trap summary code, valid with trap_o |
| sticky_o | output | 5 | Sticky exception status |
| mask_o | output | 5 | Current disable mask |
| reg_mask_o | output | 64 | Accumulated register-trap mask |

## Verification
The assertions assume that flags_i, qual_i, cvt_i and dst_i carry meaning only while op_valid_i is high, and that all inputs are driven to known values from reset on; they take no position on flags present in idle cycles. The stimulus changes inputs only at the falling edge, holds each operation for exactly one cycle, and deliberately places flags on the bus during an idle cycle and sets unused qualifier bits (rounding-mode bits) to show both are ignored. Same-cycle combinations of clear with an operation and of mask load with an operation are applied to pin down the priorities in R10 and R11.

// File: rtl/fp_trap_pkg.sv
package fp_trap_pkg;
  localparam int unsigned NFLAG = 5;
  localparam int unsigned QUAL_W = 11;

  // flag / summary code bit positions
  localparam int unsigned F_INV = 0;
  localparam int unsigned F_DZE = 1;
  localparam int unsigned F_FOV = 2;
  localparam int unsigned F_UNF = 3;
  localparam int unsigned F_INE = 4;

  // qualifier decode positions
  localparam int unsigned Q_OVE = 8;
  localparam int unsigned Q_INE = 9;
  localparam int unsigned Q_SWC = 10;

  typedef logic [NFLAG-1:0] flags_t;
endpackage

// File: rtl/fp_trap_filter.sv
module fp_trap_filter
  import fp_trap_pkg::*;
(
  input  flags_t              flags_i,
  input  logic [QUAL_W-1:0]   qual_i,
  input  logic                cvt_i,
  input  flags_t              dis_mask_i,
  output flags_t              surv_o,
  output flags_t              trap_bits_o
);
  logic swc;
  logic [QUAL_W-1:0] unused_qual;

  assign swc         = qual_i[Q_SWC];
  assign unused_qual = qual_i;

  always_comb begin
    surv_o = flags_i;
    if (!qual_i[Q_INE])          surv_o[F_INE] = 1'b0;
    if (cvt_i && !qual_i[Q_OVE]) surv_o[F_FOV] = 1'b0;
  end

  generate
    for (genvar b = 0; b < NFLAG; b++) begin : g_bit
      assign trap_bits_o[b] = surv_o[b] & (~swc | ~dis_mask_i[b]);
    end
  endgenerate
endmodule

// File: rtl/fp_trap_status.sv
module fp_trap_status
  import fp_trap_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   acc_i,
  input  flags_t surv_i,
  input  logic   clr_i,
  input  logic   mask_we_i,
  input  flags_t mask_i,
  output flags_t sticky_o,
  output flags_t dis_mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sticky_o <= '0;
    else if (clr_i)    sticky_o <= '0;
    else if (acc_i)    sticky_o <= sticky_o | surv_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        dis_mask_o <= '0;
    else if (mask_we_i) dis_mask_o <= mask_i;
  end

  // R6
  sticky_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((sticky_o & $past(sticky_o)) == $past(sticky_o)));
  // R10
  sticky_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (sticky_o == '0));
endmodule

// File: rtl/fp_trap_regmask.sv
module fp_trap_regmask #(
  parameter int unsigned MASK_W = 64,
  localparam int unsigned IDX_W = $clog2(MASK_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              clr_i,
  output logic [MASK_W-1:0] mask_o
);
  generate
    for (genvar i = 0; i < MASK_W; i++) begin : g_slot
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                  mask_o[i] <= 1'b0;
        else if (clr_i)                               mask_o[i] <= 1'b0;
        else if (hit_i && idx_i == IDX_W'(i))         mask_o[i] <= 1'b1;
      end
    end
  endgenerate

  // R9
  regmask_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((mask_o & $past(mask_o)) == $past(mask_o)));
  // R10
  regmask_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (mask_o == '0));
endmodule

// File: rtl/fp_trap_unit.sv
module fp_trap_unit
  import fp_trap_pkg::*;
#(
  parameter int unsigned REG_W   = 5,
  parameter int unsigned REG_OFS = 32,
  parameter int unsigned MASK_W  = 64,
  localparam int unsigned IDX_W  = $clog2(MASK_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [4:0]        flags_i,
  input  logic [10:0]       qual_i,
  input  logic              cvt_i,
  input  logic [REG_W-1:0]  dst_i,
  input  logic              mask_we_i,
  input  logic [4:0]        mask_i,
  input  logic              clr_i,
  output logic              trap_o,
  output logic [4:0]        trap_code_o,
  output logic [4:0]        sticky_o,
  output logic [4:0]        mask_o,
  output logic [MASK_W-1:0] reg_mask_o
);
  flags_t           surv, trap_bits;
  logic             trap_d;
  logic [IDX_W-1:0] hit_idx;

  fp_trap_filter u_filter (
    .flags_i     (flags_i),
    .qual_i      (qual_i),
    .cvt_i       (cvt_i),
    .dis_mask_i  (mask_o),
    .surv_o      (surv),
    .trap_bits_o (trap_bits)
  );

  fp_trap_status u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (op_valid_i & qual_i[Q_SWC]),
    .surv_i     (surv),
    .clr_i      (clr_i),
    .mask_we_i  (mask_we_i),
    .mask_i     (mask_i),
    .sticky_o   (sticky_o),
    .dis_mask_o (mask_o)
  );

  assign trap_d  = op_valid_i & (|trap_bits);
  assign hit_idx = IDX_W'(dst_i) + IDX_W'(REG_OFS);

  fp_trap_regmask #(.MASK_W(MASK_W)) u_regmask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (trap_d),
    .idx_i  (hit_idx),
    .clr_i  (clr_i),
    .mask_o (reg_mask_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_o      <= 1'b0;
      trap_code_o <= '0;
    end else begin
      trap_o      <= trap_d;
      trap_code_o <= trap_d ? trap_bits : '0;
    end
  end

  // R8
  trap_needs_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> $past(op_valid_i));
  // R2
  code_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o == (trap_code_o != '0));
  // R3
  ine_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !qual_i[Q_INE]) |=> !trap_code_o[F_INE]);
  // R4
  cvt_ovf_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && cvt_i && !qual_i[Q_OVE]) |=> !trap_code_o[F_FOV]);
  // R5
  nosc_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && !qual_i[Q_SWC] && !clr_i) |=> $stable(sticky_o));
  // R7
  sc_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && qual_i[Q_SWC]) |=> ((trap_code_o & $past(mask_o)) == '0));
  // R9
  regmask_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o && !$past(clr_i)) |-> reg_mask_o[$past(hit_idx)]);
  // R9
  regmask_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_mask_o[REG_OFS-1:0] == '0);
endmodule

// File: tb/tb_fp_trap_unit.sv
module tb_fp_trap_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [4:0]  flags = '0;
  logic [10:0] qual = '0;
  logic        cvt = 1'b0;
  logic [4:0]  dst = '0;
  logic        mask_we = 1'b0;
  logic [4:0]  mask_in = '0;
  logic        clr = 1'b0;
  logic        trap;
  logic [4:0]  code, sticky, mask;
  logic [63:0] rmask;

  localparam logic [10:0] QS = 11'h400, QI = 11'h200, QV = 11'h100, QRM = 11'h0C0;

  always #5 clk = ~clk;

  fp_trap_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .flags_i(flags),
    .qual_i(qual), .cvt_i(cvt), .dst_i(dst), .mask_we_i(mask_we),
    .mask_i(mask_in), .clr_i(clr), .trap_o(trap), .trap_code_o(code),
    .sticky_o(sticky), .mask_o(mask), .reg_mask_o(rmask)
  );

  typedef struct {
    logic        trap;
    logic [4:0]  code;
    logic [4:0]  sticky;
    logic [4:0]  mask;
    logic [63:0] rm;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          n_chk = 0, n_fail = 0;
  logic [4:0]  m_sticky = '0, m_mask = '0;
  logic [63:0] m_rm = '0;
  logic        done = 1'b0;

  task automatic check(input exp_t e);
    n_chk++;
    if (trap !== e.trap || code !== e.code || sticky !== e.sticky ||
        mask !== e.mask || rmask !== e.rm) begin
      n_fail++;
      $display("FAIL %s: got trap=%b code=%b sticky=%b mask=%b rm=%h exp trap=%b code=%b sticky=%b mask=%b rm=%h",
               e.tag, trap, code, sticky, mask, rmask,
               e.trap, e.code, e.sticky, e.mask, e.rm);
    end
  endtask

  // driver: one cycle of stimulus, model update, push expectation
  task automatic step(input logic v, input logic [4:0] f, input logic [10:0] qu,
                      input logic cv, input logic [4:0] d, input logic mwe,
                      input logic [4:0] m, input logic cl, input string tag);
    exp_t e;
    logic [4:0] s, t;
    @(negedge clk);
    op_valid = v; flags = f; qual = qu; cvt = cv; dst = d;
    mask_we = mwe; mask_in = m; clr = cl;
    s = f;
    if (!qu[9]) s[4] = 1'b0;
    if (cv && !qu[8]) s[2] = 1'b0;
    t = qu[10] ? (s & ~m_mask) : s;
    if (!v) t = '0;
    if (v && qu[10]) m_sticky = m_sticky | s;
    if (v && t != 0) m_rm[32 + int'(d)] = 1'b1;
    if (cl) begin m_sticky = '0; m_rm = '0; end
    if (mwe) m_mask = m;
    e.trap = (t != 0); e.code = t; e.sticky = m_sticky;
    e.mask = m_mask; e.rm = m_rm; e.tag = tag;
    @(posedge clk);
    q.push_back(e);
  endtask

  task automatic op(input logic [4:0] f, input logic [10:0] qu, input logic cv,
                    input logic [4:0] d, input string tag);
    step(1'b1, f, qu, cv, d, 1'b0, 5'd0, 1'b0, tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 5'd0, 11'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0) check(q.pop_front());
  end

  initial begin
    exp_t r;
    repeat (3) @(posedge clk);
    @(negedge clk);
    r.trap = 0; r.code = 0; r.sticky = 0; r.mask = 0; r.rm = 0; r.tag = "R1 reset";
    check(r);
    rst_n = 1'b1;
    idle("R1 after release");

    op(5'b00001, QRM, 0, 5'd3, "R2 R8 R9 invalid non-sc");
    op(5'b11111, 11'd0, 0, 5'd4, "R2 R3 all flags no ine");
    op(5'b10000, QI, 0, 5'd5, "R3 inexact requested");
    op(5'b10000, 11'd0, 0, 5'd6, "R3 inexact dropped");
    op(5'b00100, 11'd0, 1, 5'd7, "R4 cvt overflow dropped");
    op(5'b00100, QV, 1, 5'd8, "R4 cvt overflow enabled");
    op(5'b00100, 11'd0, 0, 5'd9, "R4 non-cvt overflow kept");
    step(1'b0, 5'b11111, QS | QI, 0, 5'd10, 1'b0, 5'd0, 1'b0, "R8 idle flags ignored");
    step(1'b0, 5'd0, 11'd0, 0, 5'd0, 1'b1, 5'b00101, 1'b0, "R11 mask load");
    op(5'b00001, 11'd0, 0, 5'd11, "R5 mask ignored non-sc");
    op(5'b00011, QS, 0, 5'd12, "R6 R7 sc partial mask");
    op(5'b00001, QS, 0, 5'd13, "R7 sc fully masked");
    op(5'b01000, QS | QRM, 0, 5'd14, "R6 R7 sc underflow");
    op(5'b10000, QS, 0, 5'd15, "R3 R6 sc ine dropped");
    op(5'b10000, QS | QI, 0, 5'd31, "R6 R9 sc ine dst31");
    step(1'b1, 5'b00001, QS, 0, 5'd16, 1'b1, 5'd0, 1'b0, "R11 same-cycle mask uses old");
    op(5'b00001, QS, 0, 5'd17, "R11 new mask applied");
    op(5'b00010, 11'd0, 0, 5'd0, "R5 back-to-back a");
    op(5'b01000, 11'd0, 0, 5'd1, "R5 back-to-back b");
    step(1'b0, 5'd0, 11'd0, 0, 5'd0, 1'b0, 5'd0, 1'b1, "R10 clear");
    step(1'b1, 5'b00010, QS, 0, 5'd20, 1'b0, 5'd0, 1'b1, "R10 clear beats op");
    op(5'b00100, QS, 0, 5'd21, "R6 R9 after clear");
    idle("R8 idle end");
    idle("R8 idle end2");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule